// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small processor that keeps every working value in one accumulator and runs each instruction as a chain of single-register-transfer clock steps. The block has four visible registers: the program counter, a memory address register, a memory data register and an instruction register. A state machine moves data between them and a single-port synchronous memory of 16-bit words. An instruction word holds a 4-bit operation in its upper bits and a 12-bit word address in its lower bits. The core can load, add, store, jump, return from an interrupt, and stop.

After the execute steps of each instruction, the core passes through one interrupt-check step. If the level-sensitive request is high and interrupts are enabled, the core writes the program counter and then the accumulator onto a descending stack at the top of memory. It then disables interrupts and continues at a fixed handler address. The return instruction reads the two words back in the opposite order, enables interrupts again and resumes where the program was stopped.

The current state, the registers, the interrupt enable and a stop flag are all brought out as ports. A testbench can follow the core step by step and compare the final accumulator and memory contents against a software model.

Top module: `acc_core`

## Requirements
- R1: While rst_ni is low, the core drives these values: pc_o=0, acc_o=0, state_o=0, ie_o=1, halted_o=0 and mem_we_o=0.
- R2: A fetch walks through state_o codes 0 (load address register), 1 (wait), 2 (capture data), 3 (load instruction register) and 4 (decode), one clock each. mar_o takes the program counter in step 0, and mem_addr_o shows that address in step 1. pc_o rises by one at the end of step 2, and ir_o holds the fetched word after step 3.
- R3: Bits 15:12 of an instruction word are the operation and bits 11:0 are the operand address. Operation 0x1 copies the word at the operand address into the accumulator.
- R4: Operation 0x2 adds the word at the operand address to the accumulator, modulo 2^16.
- R5: Operation 0x3 writes the accumulator to the operand address with a single write strobe.
- R6: Operation 0x4 makes the next fetch come from the operand address.
- R7: Operations 0x5 to 0xE change neither the accumulator nor memory, and the program counter just advances by one.
- R8: Operation 0x0 stops the core. halted_o goes high and state_o holds 20. From then on there are no memory writes, and the accumulator and program counter stay frozen.
- R9: After an execute phase, if irq_i=1 and ie_o=1, the core pushes the program counter (zero-extended) to word 0xFFF and then the accumulator to word 0xFFE. It then clears ie_o and continues fetching at 0x010.
- R10: While ie_o=0, a high irq_i starts no interrupt entry and writes nothing to the stack.
- R11: Operation 0xF restores the accumulator from the last pushed word and the program counter from the word before it. It then sets ie_o, and execution continues at the interrupted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Level-sensitive interrupt request |
| mem_addr_o | output | 12 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 16 | Memory read data, registered one cycle after the address |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| mar_o | output | 12 | Memory address register |
| mdr_o | output | 16 | Memory data register |
| ir_o | output | 16 | Instruction register |
| ie_o | output | 1 | Interrupt enable |
| state_o | output | 5 | Current control state code |
| halted_o | output | 1 | Core stopped on operation 0x0 |

## Verification
The bench uses the default parameters: 16-bit data, a 12-bit address, handler entry at 0x010 and stack start at 0xFFF. With these values a full 4096-word memory model fits in the bench, so stack pushes at the top of the address space, handler code at 0x010 and a data window at 0x100 can all be observed together. Random programs of loads, adds, stores and no-operation codes are compared against a bench instruction model. Directed programs cover jumps, adder wrap-around, a stop that must hold, and an interrupt whose request stays high into the handler.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int OPW = 4;
  localparam int STW = 5;

  typedef enum logic [STW-1:0] {
    S_F_MAR  = 5'd0,
    S_F_RD   = 5'd1,
    S_F_MDR  = 5'd2,
    S_F_IR   = 5'd3,
    S_DEC    = 5'd4,
    S_X_MAR  = 5'd5,
    S_X_RD   = 5'd6,
    S_X_MDR  = 5'd7,
    S_X_ACC  = 5'd8,
    S_X_WR   = 5'd9,
    S_X_JMP  = 5'd10,
    S_INT    = 5'd11,
    S_I_PC   = 5'd12,
    S_I_ACC  = 5'd13,
    S_I_VEC  = 5'd14,
    S_R_INC1 = 5'd15,
    S_R_RD1  = 5'd16,
    S_R_ACC  = 5'd17,
    S_R_RD2  = 5'd18,
    S_R_PC   = 5'd19,
    S_HALT   = 5'd20
  } state_t;

  localparam logic [OPW-1:0] OP_HALT  = 4'h0;
  localparam logic [OPW-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPW-1:0] OP_ADD   = 4'h2;
  localparam logic [OPW-1:0] OP_STORE = 4'h3;
  localparam logic [OPW-1:0] OP_JUMP  = 4'h4;
  localparam logic [OPW-1:0] OP_RETI  = 4'hF;

  typedef enum logic {ALU_PASS = 1'b0, ALU_ADD = 1'b1} alu_op_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu import acc_core_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input  alu_op_t       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/acc_stack.sv
module acc_stack #(
  parameter int unsigned AW      = 12,
  parameter int unsigned SP_INIT = 'hFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_up_o
);
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= AW'(SP_INIT);
    else if (push_i) sp_q <= sp_q - AW'(1);
    else if (pop_i)  sp_q <= sp_q + AW'(1);
  end

  assign sp_o    = sp_q;
  assign sp_up_o = sp_q + AW'(1);

  // R9
  push_pop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));

  // R11
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (sp_q == $past(sp_q) + AW'(1)));
endmodule

// File: rtl/acc_fsm.sv
module acc_fsm import acc_core_pkg::*; (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] opcode_i,
  input  logic           irq_i,
  input  logic           ie_i,
  output state_t         state_o
);
  state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_F_MAR: state_d = S_F_RD;
      S_F_RD:  state_d = S_F_MDR;
      S_F_MDR: state_d = S_F_IR;
      S_F_IR:  state_d = S_DEC;
      S_DEC: begin
        unique case (opcode_i)
          OP_LOAD, OP_ADD, OP_STORE: state_d = S_X_MAR;
          OP_JUMP:                   state_d = S_X_JMP;
          OP_RETI:                   state_d = S_R_INC1;
          OP_HALT:                   state_d = S_HALT;
          default:                   state_d = S_INT;
        endcase
      end
      S_X_MAR:  state_d = (opcode_i == OP_STORE) ? S_X_WR : S_X_RD;
      S_X_RD:   state_d = S_X_MDR;
      S_X_MDR:  state_d = S_X_ACC;
      S_X_ACC:  state_d = S_INT;
      S_X_WR:   state_d = S_INT;
      S_X_JMP:  state_d = S_INT;
      S_INT:    state_d = (irq_i && ie_i) ? S_I_PC : S_F_MAR;
      S_I_PC:   state_d = S_I_ACC;
      S_I_ACC:  state_d = S_I_VEC;
      S_I_VEC:  state_d = S_F_MAR;
      S_R_INC1: state_d = S_R_RD1;
      S_R_RD1:  state_d = S_R_ACC;
      S_R_ACC:  state_d = S_R_RD2;
      S_R_RD2:  state_d = S_R_PC;
      S_R_PC:   state_d = S_INT;
      S_HALT:   state_d = S_HALT;
      default:  state_d = S_F_MAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_F_MAR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  fetch_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_F_IR) |=> (state_q == S_DEC));

  // R10
  ie_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_INT && !ie_i) |=> (state_q == S_F_MAR));
endmodule

// File: rtl/acc_core.sv
module acc_core import acc_core_pkg::*; #(
  parameter int unsigned DW         = 16,
  parameter int unsigned AW         = 12,
  parameter int unsigned RESET_PC   = 'h000,
  parameter int unsigned HANDLER_PC = 'h010,
  parameter int unsigned SP_INIT    = 'hFFF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           irq_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_we_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [AW-1:0]  pc_o,
  output logic [DW-1:0]  acc_o,
  output logic [AW-1:0]  mar_o,
  output logic [DW-1:0]  mdr_o,
  output logic [DW-1:0]  ir_o,
  output logic           ie_o,
  output logic [STW-1:0] state_o,
  output logic           halted_o
);
  localparam logic [AW-1:0] PC_RST = AW'(RESET_PC);
  localparam logic [AW-1:0] PC_VEC = AW'(HANDLER_PC);

  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] acc_q, mdr_q, ir_q, alu_y, pc_ext;
  logic          ie_q;
  logic          push, pop;
  logic [AW-1:0] sp, sp_up;
  logic [OPW-1:0] opcode;
  alu_op_t       alu_op;
  state_t        state;

  assign opcode = ir_q[DW-1 -: OPW];
  assign alu_op = (opcode == OP_ADD) ? ALU_ADD : ALU_PASS;

  acc_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .irq_i    (irq_i),
    .ie_i     (ie_q),
    .state_o  (state)
  );

  acc_alu #(.DW(DW)) u_alu (
    .op_i (alu_op),
    .a_i  (acc_q),
    .b_i  (mdr_q),
    .y_o  (alu_y)
  );

  assign push = (state == S_I_PC) || (state == S_I_ACC);
  assign pop  = (state == S_R_INC1) || (state == S_R_ACC);

  acc_stack #(.AW(AW), .SP_INIT(SP_INIT)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .sp_o    (sp),
    .sp_up_o (sp_up)
  );

  generate
    if (DW > AW) begin : g_pc_zext
      assign pc_ext = {{(DW-AW){1'b0}}, pc_q};
    end else begin : g_pc_trunc
      assign pc_ext = pc_q[DW-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= PC_RST;
      acc_q <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      ie_q  <= 1'b1;
    end else begin
      unique case (state)
        S_F_MAR: mar_q <= pc_q;
        S_F_MDR: begin
          mdr_q <= mem_rdata_i;
          pc_q  <= pc_q + AW'(1);
        end
        S_F_IR:   ir_q  <= mdr_q;
        S_X_MAR:  mar_q <= ir_q[AW-1:0];
        S_X_MDR:  mdr_q <= mem_rdata_i;
        S_X_ACC:  acc_q <= alu_y;
        S_X_JMP:  pc_q  <= ir_q[AW-1:0];
        S_I_VEC: begin
          pc_q <= PC_VEC;
          ie_q <= 1'b0;
        end
        S_R_INC1: mar_q <= sp_up;
        S_R_ACC: begin
          acc_q <= mem_rdata_i;
          mar_q <= sp_up;
        end
        S_R_PC: begin
          pc_q <= mem_rdata_i[AW-1:0];
          ie_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = push ? sp : mar_q;
  assign mem_we_o    = push || (state == S_X_WR);
  assign mem_wdata_o = (state == S_I_PC) ? pc_ext : acc_q;

  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign mar_o    = mar_q;
  assign mdr_o    = mdr_q;
  assign ir_o     = ir_q;
  assign ie_o     = ie_q;
  assign state_o  = state;
  assign halted_o = (state == S_HALT);

  // R2
  pc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_F_MDR) |=> (pc_q == $past(pc_q) + AW'(1)));

  // R5
  store_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_X_WR) |-> (mem_we_o && mem_addr_o == ir_q[AW-1:0] && mem_wdata_o == acc_q));

  // R9
  push_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_I_PC) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) - AW'(1)
                           && mem_wdata_o == acc_q));

  // R9
  vec_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_I_VEC) |=> (pc_q == PC_VEC && !ie_q));

  // R11
  reti_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_R_PC) |=> (ie_q && pc_q == $past(mem_rdata_i[AW-1:0])));

  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_we_o && $stable(acc_q) && $stable(pc_q)));
endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
  localparam int MW = 4096;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq = 1'b0;
  logic        load_req = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we;
  logic [11:0] pc, mar;
  logic [15:0] acc, mdr, ir;
  logic        ie, halted;
  logic [4:0]  state;

  logic [15:0] mem [0:MW-1];
  logic [15:0] img [0:MW-1];
  logic [15:0] rm  [0:MW-1];
  logic [15:0] ref_acc;
  logic [11:0] ref_pc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  acc_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata),
    .pc_o(pc), .acc_o(acc), .mar_o(mar), .mdr_o(mdr), .ir_o(ir),
    .ie_o(ie), .state_o(state), .halted_o(halted)
  );

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < MW; i++) mem[i] <= img[i];
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic img_clear();
    for (int i = 0; i < MW; i++) img[i] = 16'h0000;
  endtask

  task automatic boot();
    @(negedge clk);
    rst_ni = 1'b0;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_halt(input int maxc);
    int n = 0;
    while (!halted && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  // instruction-level model of the requirements
  task automatic ref_run();
    logic [15:0] w;
    logic [11:0] a;
    ref_pc = 12'h000;
    ref_acc = 16'h0000;
    for (int s = 0; s < 500; s++) begin
      w = rm[ref_pc];
      a = w[11:0];
      ref_pc = ref_pc + 12'd1;
      if (w[15:12] == 4'h0) break;
      case (w[15:12])
        4'h1: ref_acc = rm[a];
        4'h2: ref_acc = ref_acc + rm[a];
        4'h3: rm[a] = ref_acc;
        4'h4: ref_pc = a;
        default: ;
      endcase
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd24680));

    // ---- R1 / R2 / R7: reset, fetch steps, no-op codes
    img_clear();
    img[0] = 16'h1100; img[1] = 16'h5ABC; img[2] = 16'hE123;
    img[3] = 16'h3101; img[4] = 16'h0000;
    img[12'h100] = 16'h7777; img[12'h123] = 16'h4444; img[12'hABC] = 16'h1111;
    @(negedge clk);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    chk(pc == 0 && acc == 0 && state == 0, "R1 pc/acc/state in reset", {pc, acc, 4'h0}, 32'h0);
    chk(ie == 1 && halted == 0 && mem_we == 0, "R1 ie/halted/we in reset", {ie, halted, mem_we}, 3'b100);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(state == 1 && mar == 12'h000 && mem_addr == 12'h000, "R2 step 1 address", {state, mar}, {5'd1, 12'h000});
    @(negedge clk);
    chk(state == 2, "R2 step 2 state", state, 2);
    @(negedge clk);
    chk(state == 3 && pc == 12'h001 && mdr == 16'h1100, "R2 step 3 pc/mdr", {pc, mdr}, {12'h001, 16'h1100});
    @(negedge clk);
    chk(state == 4 && ir == 16'h1100, "R2 step 4 ir", {state, ir}, {5'd4, 16'h1100});
    run_halt(400);
    chk(acc == 16'h7777 && mem[12'h101] == 16'h7777, "R7 acc after no-ops", acc, 16'h7777);
    chk(mem[12'h123] == 16'h4444 && mem[12'hABC] == 16'h1111, "R7 memory untouched by no-ops",
        {mem[12'h123], mem[12'hABC]}, {16'h4444, 16'h1111});
    chk(pc == 12'h005, "R7 pc advanced by one per no-op", pc, 12'h005);

    // ---- R4: adder wrap
    img_clear();
    img[0] = 16'h1100; img[1] = 16'h2101; img[2] = 16'h3102; img[3] = 16'h0000;
    img[12'h100] = 16'hFFFF; img[12'h101] = 16'h0002;
    boot();
    run_halt(400);
    chk(acc == 16'h0001 && mem[12'h102] == 16'h0001, "R4 add wraps modulo 2^16", acc, 16'h0001);

    // ---- R6 / R8: jump and stop hold
    img_clear();
    img[0] = 16'h4020; img[1] = 16'h1101;
    img[12'h020] = 16'h1100; img[12'h021] = 16'h3102; img[12'h022] = 16'h0000;
    img[12'h100] = 16'hAAAA; img[12'h101] = 16'h5555;
    boot();
    run_halt(400);
    chk(acc == 16'hAAAA && mem[12'h102] == 16'hAAAA, "R6 jump skipped word 1", acc, 16'hAAAA);
    chk(pc == 12'h023, "R6 pc after jump target run", pc, 12'h023);
    chk(halted == 1 && state == 20, "R8 stop state", state, 20);
    repeat (20) @(negedge clk);
    chk(halted == 1 && state == 20 && acc == 16'hAAAA && pc == 12'h023, "R8 stop holds",
        {state, pc}, {5'd20, 12'h023});

    // ---- R9 / R10 / R11: interrupt with request held into the handler
    img_clear();
    img[0] = 16'h1100; img[1] = 16'h2101; img[2] = 16'h5000; img[3] = 16'h0000;
    img[12'h010] = 16'h1102; img[12'h011] = 16'h3103; img[12'h012] = 16'hF000;
    img[12'h100] = 16'h1234; img[12'h101] = 16'h0F0F; img[12'h102] = 16'hBEEF;
    img[12'hFFD] = 16'hDEAD;
    irq = 1'b1;
    boot();
    begin
      int n = 0;
      while (ie && n < 200) begin
        @(negedge clk);
        n++;
      end
    end
    chk(ie == 0 && pc == 12'h010, "R9 entry at handler with ie cleared", {ie, pc}, {1'b0, 12'h010});
    chk(mem[12'hFFF] == 16'h0001 && mem[12'hFFE] == 16'h1234, "R9 pushed pc then acc",
        {mem[12'hFFF], mem[12'hFFE]}, {16'h0001, 16'h1234});
    repeat (15) @(negedge clk);
    chk(ie == 0 && pc >= 12'h010 && pc <= 12'h013 && mem[12'hFFD] == 16'hDEAD,
        "R10 held request ignored while disabled", {ie, pc}, {1'b0, 12'h012});
    irq = 1'b0;
    run_halt(600);
    chk(mem[12'h103] == 16'hBEEF, "R9 handler ran", mem[12'h103], 16'hBEEF);
    chk(acc == 16'h2143, "R11 acc restored then add", acc, 16'h2143);
    chk(pc == 12'h004 && ie == 1, "R11 resumed and ie set", {ie, pc}, {1'b1, 12'h004});
    chk(mem[12'hFFD] == 16'hDEAD, "R10 no extra stack write", mem[12'hFFD], 16'hDEAD);

    // ---- R3 / R4 / R5 / R7: random programs against the model
    for (int p = 0; p < 24; p++) begin
      int n;
      img_clear();
      n = 4 + int'($urandom % 10);
      for (int i = 0; i < n; i++) begin
        logic [3:0] op;
        case ($urandom % 4)
          0: op = 4'h1;
          1: op = 4'h2;
          2: op = 4'h3;
          default: op = 4'(5 + ($urandom % 10));
        endcase
        img[i] = {op, 12'h100 + 12'($urandom % 16)};
      end
      img[n] = 16'h0000;
      for (int j = 0; j < 16; j++) img[12'h100 + j] = 16'($urandom);
      for (int i = 0; i < MW; i++) rm[i] = img[i];
      ref_run();
      boot();
      run_halt(2000);
      chk(halted == 1, "R8 random program stopped", halted, 1);
      chk(acc == ref_acc, "R3 R4 random accumulator", acc, ref_acc);
      chk(pc == ref_pc, "R7 random final pc", pc, ref_pc);
      begin
        bit same = 1'b1;
        for (int j = 0; j < 16; j++) if (mem[12'h100 + j] !== rm[12'h100 + j]) same = 1'b0;
        chk(same, "R5 random data window", same, 1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule